// File: doc/BRIEF.md
# Circular Buffer Rate Matcher with Modulation-Order Interleave

This block turns one encoded LDPC codeword into a rate-matched bit stream of a chosen length. The codeword arrives as a sequence of wide input beats, one lifting-size segment per beat. Only the low `Zc` bits of each beat carry data. The beats are held in an on-chip circular buffer. Once the last beat is in, the block walks the buffer from a start offset `k0`. It wraps at the limited buffer length `Ncb` and passes over the span of filler positions. It collects exactly `E` bits this way.

The collected bits are then interleaved for the modulation order `Qm`. They are laid out row by row in a `Qm` by `E/Qm` grid and read back column by column. The result is packed into 32-bit output words. Each block gets a start marker on its first word and an end marker on its last.

Configuration is loaded through a four-beat 32-bit write before each block. The block produces one interleaved bit per clock cycle. While it works on a block it holds off new input.

Top module: `cbuf_rate_matcher`

## Requirements
- R1: Configuration is taken from four consecutive `cfg_valid` beats. Beat 0 carries Ncb in [31:16] and E in [15:0]. Beat 1 carries Zc in [28:20] and Qm in [11:8]; bits [18] (graph) and [17:12] (row count) are accepted but unused. Beat 2 carries E/Qm in [31:16] and k0 in [14:0]. Beat 3 carries the filler end (K-2)·Zc in [29:16] and the filler start (Kp-2)·Zc in [13:0].
- R2: Input beats are stored in order, from the beat with `sink_sop` through the beat with `sink_eop`. Codeword position p is bit p mod Zc of beat p div Zc. Bits at and above Zc in a beat are ignored.
- R3: Each block produces exactly ceil(E/32) output words (E > 32).
- R4: Bit selection begins at codeword position k0 and continues upward. After position Ncb-1 it wraps to 0, and it may wrap more than once.
- R5: Positions p with filler start ≤ p < filler end are skipped and do not count toward E.
- R6: With Qm in {1, 2, 4, 6, 8}, output bit j is selected bit (j mod Qm)·(E/Qm) + (j div Qm).
- R7: Output bit j is in bit (j mod 32) of word (j div 32), so bit 0 goes first. Bits of the last word beyond E are zero.
- R8: `source_valid` is high for one cycle per word. `source_sop` is high only on the first word and `source_eop` only on the last.
- R9: `sink_ready` goes low in the cycle after the `sink_eop` beat is accepted. It stays low while output words are sent and is high again in the cycle after the `source_eop` word.
- R10: After reset `sink_ready` is high and `source_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration beat strobe |
| cfg_data | input | 32 | Configuration beat payload |
| sink_valid | input | 1 | Input segment qualifier |
| sink_sop | input | 1 | First segment of a codeword |
| sink_eop | input | 1 | Last segment of a codeword |
| sink_data | input | SEG_W | One lifting-size segment, bit 0 lowest position |
| sink_ready | output | 1 | Input can be accepted |
| source_valid | output | 1 | Output word qualifier |
| source_sop | output | 1 | First word of a block |
| source_eop | output | 1 | Last word of a block |
| source_data | output | OUT_W | Packed interleaved bits |

## Verification
The bench builds the block with 16-bit segments, an eight-segment buffer and a 512-bit selection store. These sizes keep codewords short, so a short run can cover `E` values well past `Ncb`, with several wraps, and start offsets at both ends of the buffer. A sweep moves `k0` across the whole buffer while `Qm` cycles through all five orders with a fixed filler span. A set of directed cases adds a buffer limit below the stored length, filler running up to `Ncb`, `E` just above one word, and lifting sizes below the segment width that leave junk in the upper input bits.

// File: rtl/rm_pkg.sv
package rm_pkg;
   localparam int POS_W = 16;

   typedef struct packed {
      logic [15:0] ncb;
      logic [15:0] e;
      logic [15:0] eq;
      logic [8:0]  zc;
      logic [3:0]  qm;
      logic [14:0] k0;
      logic [13:0] fill_end;
      logic [13:0] fill_beg;
   } rm_cfg_t;
endpackage

// File: rtl/rm_cfg_regs.sv
module rm_cfg_regs
   import rm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_valid,
   input  logic [31:0] cfg_data,
   output rm_cfg_t     cfg
);
   logic [1:0] beat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beat_q <= '0;
         cfg    <= '0;
      end else if (cfg_valid) begin
         beat_q <= beat_q + 2'd1;
         case (beat_q)
            2'd0: begin
               cfg.ncb <= cfg_data[31:16];
               cfg.e   <= cfg_data[15:0];
            end
            2'd1: begin
               cfg.zc <= cfg_data[28:20];
               cfg.qm <= cfg_data[11:8];
            end
            2'd2: begin
               cfg.eq <= cfg_data[31:16];
               cfg.k0 <= cfg_data[14:0];
            end
            default: begin
               cfg.fill_end <= cfg_data[29:16];
               cfg.fill_beg <= cfg_data[13:0];
            end
         endcase
      end
   end
endmodule

// File: rtl/rm_cbuf_mem.sv
module rm_cbuf_mem #(
   parameter int SEG_W = 384,
   parameter int DEPTH = 68,
   localparam int SEG_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int OFF_W  = (SEG_W > 1) ? $clog2(SEG_W) : 1
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [SEG_AW-1:0] wr_addr,
   input  logic [SEG_W-1:0]  wr_data,
   input  logic [SEG_AW-1:0] rd_seg,
   input  logic [OFF_W-1:0]  rd_off,
   output logic              rd_bit
);
   logic [SEG_W-1:0] mem [DEPTH];
   logic [SEG_W-1:0] rd_word;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_word = mem[rd_seg];
   assign rd_bit  = rd_word[rd_off];
endmodule

// File: rtl/rm_bit_walker.sv
module rm_bit_walker
   import rm_pkg::*;
#(
   parameter int SEG_W = 384,
   parameter int DEPTH = 68,
   localparam int SEG_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int OFF_W  = (SEG_W > 1) ? $clog2(SEG_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  rm_cfg_t           cfg,
   input  logic              rd_bit,
   output logic [SEG_AW-1:0] rd_seg,
   output logic [OFF_W-1:0]  rd_off,
   output logic              sel_valid,
   output logic              sel_bit,
   output logic              sel_last
);
   typedef enum logic [1:0] {W_IDLE, W_SEEK, W_WALK} wst_t;

   wst_t             st;
   logic [POS_W-1:0] rem, pos, cnt;
   logic [SEG_AW-1:0] seg;
   logic [OFF_W-1:0] off;
   logic             filler, take, wrap, zlast;
   logic [8:0]       off_ext;

   assign off_ext   = 9'(off);
   assign filler    = (pos >= {2'b0, cfg.fill_beg}) && (pos < {2'b0, cfg.fill_end});
   assign take      = (st == W_WALK) && !filler;
   assign wrap      = (pos == cfg.ncb - 16'd1);
   assign zlast     = (off_ext == cfg.zc - 9'd1);
   assign sel_valid = take;
   assign sel_bit   = rd_bit;
   assign sel_last  = take && (cnt == cfg.e - 16'd1);
   assign rd_seg    = seg;
   assign rd_off    = off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= W_IDLE;
         rem <= '0;
         pos <= '0;
         cnt <= '0;
         seg <= '0;
         off <= '0;
      end else begin
         case (st)
            W_IDLE: if (start) begin
               st  <= W_SEEK;
               rem <= {1'b0, cfg.k0};
               pos <= {1'b0, cfg.k0};
               seg <= '0;
               cnt <= '0;
            end
            W_SEEK: begin
               if (rem >= {7'b0, cfg.zc}) begin
                  rem <= rem - {7'b0, cfg.zc};
                  seg <= seg + 1'b1;
               end else begin
                  off <= OFF_W'(rem);
                  st  <= W_WALK;
               end
            end
            W_WALK: begin
               if (take) cnt <= cnt + 16'd1;
               if (sel_last) st <= W_IDLE;
               if (wrap) begin
                  pos <= '0;
                  seg <= '0;
                  off <= '0;
               end else begin
                  pos <= pos + 16'd1;
                  if (zlast) begin
                     off <= '0;
                     seg <= seg + 1'b1;
                  end else begin
                     off <= off + 1'b1;
                  end
               end
            end
            default: st <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rm_interleaver.sv
module rm_interleaver
   import rm_pkg::*;
#(
   parameter int MAX_E = 2048,
   parameter int OUT_W = 32,
   localparam int EA_W = $clog2(MAX_E),
   localparam int BP_W = $clog2(OUT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  rm_cfg_t          cfg,
   input  logic             sel_valid,
   input  logic             sel_bit,
   input  logic             sel_last,
   output logic             src_valid,
   output logic             src_sop,
   output logic             src_eop,
   output logic [OUT_W-1:0] src_data
);
   typedef enum logic {I_FILL, I_EMIT} ist_t;

   ist_t             st;
   logic [MAX_E-1:0] selbuf;
   logic [EA_W-1:0]  wcnt;
   logic [3:0]       row;
   logic [POS_W-1:0] base, col, j, rd_idx;
   logic [BP_W-1:0]  bitpos;
   logic [OUT_W-1:0] word, nxt_word;
   logic             first, cur_bit, last_bit, word_done;

   assign rd_idx    = base + col;
   assign cur_bit   = selbuf[rd_idx[EA_W-1:0]];
   assign nxt_word  = word | (OUT_W'(cur_bit) << bitpos);
   assign last_bit  = (j == cfg.e - 16'd1);
   assign word_done = (bitpos == BP_W'(OUT_W - 1)) || last_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= I_FILL;
         selbuf    <= '0;
         wcnt      <= '0;
         row       <= '0;
         base      <= '0;
         col       <= '0;
         j         <= '0;
         bitpos    <= '0;
         word      <= '0;
         first     <= 1'b0;
         src_valid <= 1'b0;
         src_sop   <= 1'b0;
         src_eop   <= 1'b0;
         src_data  <= '0;
      end else begin
         src_valid <= 1'b0;
         src_sop   <= 1'b0;
         src_eop   <= 1'b0;
         case (st)
            I_FILL: if (sel_valid) begin
               selbuf[wcnt] <= sel_bit;
               wcnt         <= wcnt + 1'b1;
               if (sel_last) begin
                  st     <= I_EMIT;
                  row    <= '0;
                  base   <= '0;
                  col    <= '0;
                  j      <= '0;
                  bitpos <= '0;
                  word   <= '0;
                  first  <= 1'b1;
               end
            end
            default: begin
               if (word_done) begin
                  src_valid <= 1'b1;
                  src_sop   <= first;
                  src_eop   <= last_bit;
                  src_data  <= nxt_word;
                  first     <= 1'b0;
                  word      <= '0;
                  bitpos    <= '0;
               end else begin
                  word   <= nxt_word;
                  bitpos <= bitpos + 1'b1;
               end
               if (row == cfg.qm - 4'd1) begin
                  row  <= '0;
                  base <= '0;
                  col  <= col + 16'd1;
               end else begin
                  row  <= row + 4'd1;
                  base <= base + cfg.eq;
               end
               j <= j + 16'd1;
               if (last_bit) begin
                  st   <= I_FILL;
                  wcnt <= '0;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/cbuf_rate_matcher.sv
module cbuf_rate_matcher
   import rm_pkg::*;
#(
   parameter int SEG_W = 384,
   parameter int DEPTH = 68,
   parameter int MAX_E = 2048,
   parameter int OUT_W = 32,
   localparam int SEG_AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int OFF_W  = (SEG_W > 1) ? $clog2(SEG_W) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_valid,
   input  logic [31:0]      cfg_data,
   input  logic             sink_valid,
   input  logic             sink_sop,
   input  logic             sink_eop,
   input  logic [SEG_W-1:0] sink_data,
   output logic             sink_ready,
   output logic             source_valid,
   output logic             source_sop,
   output logic             source_eop,
   output logic [OUT_W-1:0] source_data
);
   generate
      if (SEG_W < 2 || SEG_W > 512) begin : g_bad_seg
         $error("SEG_W must lie in 2..512");
      end
      if (MAX_E <= OUT_W || (MAX_E & (MAX_E - 1)) != 0) begin : g_bad_e
         $error("MAX_E must be a power of two above OUT_W");
      end
      if (OUT_W < 2) begin : g_bad_out
         $error("OUT_W must be at least 2");
      end
   endgenerate

   typedef enum logic {P_LOAD, P_RUN} phase_t;

   rm_cfg_t           cfg;
   phase_t            phase;
   logic              start_q, accept, sel_valid, sel_bit, sel_last, rd_bit;
   logic [SEG_AW-1:0] addr_q, wr_addr, rd_seg;
   logic [OFF_W-1:0]  rd_off;

   assign sink_ready = (phase == P_LOAD);
   assign accept     = sink_valid && sink_ready;
   assign wr_addr    = sink_sop ? '0 : addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= P_LOAD;
         addr_q  <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (accept) begin
            addr_q <= wr_addr + 1'b1;
            if (sink_eop) begin
               phase   <= P_RUN;
               start_q <= 1'b1;
            end
         end
         if (phase == P_RUN && source_eop) phase <= P_LOAD;
      end
   end

   rm_cfg_regs u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_data(cfg_data), .cfg(cfg)
   );

   rm_cbuf_mem #(.SEG_W(SEG_W), .DEPTH(DEPTH)) u_mem (
      .clk(clk), .wr_en(accept), .wr_addr(wr_addr), .wr_data(sink_data),
      .rd_seg(rd_seg), .rd_off(rd_off), .rd_bit(rd_bit)
   );

   rm_bit_walker #(.SEG_W(SEG_W), .DEPTH(DEPTH)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(start_q), .cfg(cfg), .rd_bit(rd_bit),
      .rd_seg(rd_seg), .rd_off(rd_off),
      .sel_valid(sel_valid), .sel_bit(sel_bit), .sel_last(sel_last)
   );

   rm_interleaver #(.MAX_E(MAX_E), .OUT_W(OUT_W)) u_ilv (
      .clk(clk), .rst_n(rst_n), .cfg(cfg),
      .sel_valid(sel_valid), .sel_bit(sel_bit), .sel_last(sel_last),
      .src_valid(source_valid), .src_sop(source_sop),
      .src_eop(source_eop), .src_data(source_data)
   );
endmodule

// File: rtl/rm_checker.sv
module rm_checker (
   input logic clk,
   input logic rst_n,
   input logic sink_valid,
   input logic sink_eop,
   input logic sink_ready,
   input logic source_valid,
   input logic source_sop,
   input logic source_eop
);
   p_sop_on_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      source_sop |-> source_valid);

   p_eop_on_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      source_eop |-> source_valid);

   p_hold_off_while_emit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      source_valid |-> !sink_ready);

   p_close_after_eop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sink_valid && sink_ready && sink_eop) |=> !sink_ready);

   p_reopen_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
      source_eop |=> sink_ready);

   p_single_word_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      source_eop |=> !source_valid);
endmodule

bind cbuf_rate_matcher rm_checker u_rm_checker (
   .clk(clk), .rst_n(rst_n), .sink_valid(sink_valid), .sink_eop(sink_eop),
   .sink_ready(sink_ready), .source_valid(source_valid),
   .source_sop(source_sop), .source_eop(source_eop)
);

// File: tb/cbuf_rate_matcher_test.sv
module cbuf_rate_matcher_test;
   localparam int SEG_W = 16;
   localparam int DEPTH = 8;
   localparam int MAX_E = 512;
   localparam int OUT_W = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_valid = 1'b0;
   logic [31:0]      cfg_data = '0;
   logic             sink_valid = 1'b0, sink_sop = 1'b0, sink_eop = 1'b0;
   logic [SEG_W-1:0] sink_data = '0;
   logic             sink_ready, source_valid, source_sop, source_eop;
   logic [OUT_W-1:0] source_data;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic cw   [0:127];
   logic sel  [0:MAX_E-1];
   logic outb [0:MAX_E+OUT_W-1];

   always #10 clk = ~clk;

   cbuf_rate_matcher #(.SEG_W(SEG_W), .DEPTH(DEPTH), .MAX_E(MAX_E), .OUT_W(OUT_W)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_data(cfg_data),
      .sink_valid(sink_valid), .sink_sop(sink_sop), .sink_eop(sink_eop),
      .sink_data(sink_data), .sink_ready(sink_ready), .source_valid(source_valid),
      .source_sop(source_sop), .source_eop(source_eop), .source_data(source_data)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "WATCHDOG", "run did not finish", cycles, 150000);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // R1 beat layout
   task automatic write_cfg(input int ncb, e, zc, qm, eq, k0, fe, fs);
      logic [31:0] b [4];
      b[0] = {ncb[15:0], e[15:0]};
      b[1] = {3'b0, zc[8:0], 1'b0, 1'b1, 6'd12, qm[3:0], 8'h00};
      b[2] = {eq[15:0], 1'b0, k0[14:0]};
      b[3] = {2'b0, fe[13:0], 2'b0, fs[13:0]};
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         cfg_valid = 1'b1;
         cfg_data  = b[i];
      end
      @(negedge clk);
      cfg_valid = 1'b0;
      cfg_data  = $urandom;
   endtask

   task automatic run_case(input int zc, nseg, ncb, qm, eq, k0, fs, fe);
      int e, nwords, got, p, cnt, wait_cnt;
      logic [31:0] expw;
      bit saw_eop;
      e = qm * eq;
      nwords = (e + OUT_W - 1) / OUT_W;
      for (int i = 0; i < 128; i++) cw[i] = 1'($urandom);
      // R4 R5 selection
      p = k0; cnt = 0;
      while (cnt < e) begin
         if (!(p >= fs && p < fe)) begin
            sel[cnt] = cw[p];
            cnt++;
         end
         p = (p + 1) % ncb;
      end
      // R6 interleave, R7 packing with zero pad
      for (int j = 0; j < MAX_E + OUT_W; j++)
         outb[j] = (j < e) ? sel[(j % qm) * eq + (j / qm)] : 1'b0;
      write_cfg(ncb, e, zc, qm, eq, k0, fe, fs);
      // R2: upper bits carry junk
      for (int s = 0; s < nseg; s++) begin
         @(negedge clk);
         sink_valid = 1'b1;
         sink_sop   = (s == 0);
         sink_eop   = (s == nseg - 1);
         sink_data  = SEG_W'($urandom);
         for (int b = 0; b < zc; b++) sink_data[b] = cw[s * zc + b];
      end
      @(negedge clk);
      sink_valid = 1'b0; sink_sop = 1'b0; sink_eop = 1'b0;
      check(sink_ready == 1'b0, "R9", "ready after last input beat", sink_ready, 0);
      got = 0; saw_eop = 1'b0; wait_cnt = 0;
      while (!saw_eop && wait_cnt < 4000) begin
         if (source_valid) begin
            expw = '0;
            for (int b = 0; b < OUT_W; b++) expw[b] = outb[got * OUT_W + b];
            check(source_data == expw, "R6", $sformatf("word %0d data", got), source_data, expw);
            check(source_sop == (got == 0), "R8", "sop flag", source_sop, got == 0);
            check(source_eop == (got == nwords - 1), "R8", "eop flag", source_eop, got == nwords - 1);
            check(sink_ready == 1'b0, "R9", "ready while emitting", sink_ready, 0);
            got++;
            saw_eop = source_eop;
         end
         if (!saw_eop) begin
            @(negedge clk);
            wait_cnt++;
         end
      end
      check(got == nwords, "R3", "word count", got, nwords);
      @(negedge clk);
      check(sink_ready == 1'b1, "R9", "ready after last word", sink_ready, 1);
      check(source_valid == 1'b0, "R8", "valid after last word", source_valid, 0);
   endtask

   initial begin
      int qms [5];
      qms = '{1, 2, 4, 6, 8};
      repeat (4) @(negedge clk);
      check(sink_ready == 1'b1, "R10", "ready in reset", sink_ready, 1);
      check(source_valid == 1'b0, "R10", "valid in reset", source_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(sink_ready == 1'b1, "R10", "ready after reset", sink_ready, 1);
      check(source_valid == 1'b0, "R10", "valid after reset", source_valid, 0);

      // R4 R5 R6 sweep: k0 across the buffer, all modulation orders
      for (int k = 0; k < 40; k += 3)
         run_case(8, 5, 40, qms[(k / 3) % 5], 40, k, 12, 16);

      // directed corners
      run_case(12, 6, 72, 2, 40, 0, 0, 0);      // R4 no filler, from zero
      run_case(12, 6, 72, 1, 33, 5, 0, 0);      // R7 E just above one word
      run_case(12, 6, 72, 4, 16, 70, 20, 30);   // R4 early wrap
      run_case(12, 6, 72, 6, 20, 36, 10, 22);   // R5 multiple wraps
      run_case(12, 6, 72, 8, 24, 71, 60, 72);   // R5 filler up to Ncb
      run_case(16, 8, 128, 2, 128, 100, 40, 48);// R3 full store
      run_case(5, 4, 20, 4, 10, 19, 3, 6);      // R2 small lifting size
      run_case(12, 6, 50, 2, 45, 49, 0, 0);     // R4 limited buffer
      run_case(12, 6, 72, 8, 8, 0, 24, 30);     // R6 E exactly two words

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule